// File: doc/BRIEF.md
# Prioritized Interrupt Level Controller

This block gathers interrupt requests arranged as numbered levels. Each level owns a bank of independent source bits, and a one-bit-per-level status word shows which levels have any source pending. Every cycle, combinational logic works on the registered state. It merges the external level status with a software request vector, picks the highest pending level, and builds a mask of every contributing level. It raises a request when that level is above the current priority mask.

While a request is raised, the level and mask are captured into a holding stage and a valid flag is set. An acknowledge strobe moves the held values into the interrupt-summary and interrupt-identifier registers and drops the flag. A separate pending output reports any posted source, but only while the program counter is word aligned. Malformed commands and stray acknowledges produce a one-cycle error pulse.

The holding stage is a two-state machine. `ST_IDLE` means nothing is held. Its transition `IDLE->HELD` fires on a clock edge where a request is raised, and the level and mask are captured. `ST_HELD` means held values are valid. Its transition `HELD->IDLE` fires on an acknowledge, which writes the identification registers. If no acknowledge arrives while a request is raised, the transition `HELD->HELD` recaptures the current level and mask.

Top module: `irq_level_ctrl`

## Requirements
- R1: A post command (`post_vld`) with an in-range level and index sets that source bit on the next clock edge, and the level then counts as pending in the status word.
- R2: A clear command with an in-range level and index clears that source bit. The level stays pending until its last source bit is cleared.
- R3: `clr_all` zeroes every source bit and the whole status word on the next edge, and overrides a post or clear issued in the same cycle.
- R4: `pend` is 1 exactly when the status word (levels 0 to 31) is nonzero and `pc_lo` equals 2'b00.
- R5: Software request bits 1 to 15 are scanned from low to high. A set bit k gives candidate level k − 1 + 1 (= k), and the highest one wins. Bits 0 and 16 to 31 of `sw_req` are ignored.
- R6: External status bits 16 to 31 are scanned after the software bits. A pending level j gives candidate level j, so any pending external level overrides every software candidate. Status bit 0 never produces a level.
- R7: The summary mask has bit k set for every set software bit k in 1..15 and bit j set for every pending external level j in 16..31, and no other bits.
- R8: `irq_req` is 1 exactly when the computed level is nonzero and strictly greater than `cur_ipl`. It is not gated by `pc_lo`.
- R9: On each edge where `irq_req` is 1 and no acknowledge is taken from `ST_HELD`, the level and mask are captured and `info_vld` is 1 afterwards. An `ack` while `info_vld` is 1 loads `intid_q` and `isr_q` with the held values on that edge and clears `info_vld`. `intid_q` and `isr_q` change on no other edge, and all outputs are 0 after reset.
- R10: A post or clear whose level is 32 or more, or whose index is 64 or more, changes no state and makes `err` 1 for the cycle after the command's edge.
- R11: An `ack` while `info_vld` is 0 leaves `intid_q` and `isr_q` unchanged and makes `err` 1 for the cycle after that edge.
- R12: When a post and a clear name the same level and index in one cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| post_vld | input | 1 | Post command strobe |
| post_lvl | input | 6 | Level addressed by the post command |
| post_idx | input | 7 | Source index addressed by the post command |
| clr_vld | input | 1 | Clear command strobe |
| clr_lvl | input | 6 | Level addressed by the clear command |
| clr_idx | input | 7 | Source index addressed by the clear command |
| clr_all | input | 1 | Clear every source of every level |
| sw_req | input | 32 | Software request vector |
| cur_ipl | input | 5 | Current priority mask level |
| pc_lo | input | 2 | Two low bits of the program counter |
| ack | input | 1 | Acknowledge strobe |
| pend | output | 1 | Any level pending while aligned |
| irq_req | output | 1 | Request to the trap logic |
| info_vld | output | 1 | Held level and mask are valid |
| intid_q | output | 5 | Interrupt identifier register |
| isr_q | output | 32 | Interrupt summary register |
| err | output | 1 | One-cycle error pulse |

## Verification
The source banks and the status word change on the edge that takes a command. `pend` and `irq_req` are combinational on that state, so they are sampled just after that edge. `err` is registered, so it is also sampled just after the edge that took the offending command. The held values need one more edge to be captured, and the identification registers change on the edge that takes `ack`. The bench therefore waits one edge after a command, then raises `ack` for exactly one further edge, and reads `intid_q` and `isr_q` just after it. All inputs are driven and all outputs read two time units after a rising edge, so no check depends on process ordering at the edge.

// File: rtl/irq_level_pkg.sv
package irq_level_pkg;

    // Holding stage of the level/mask pair
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HELD = 1'b1
    } info_state_e;

endpackage

// File: rtl/irq_src_bank.sv
// Per-level source bit banks plus the level status word.
module irq_src_bank #(
    parameter int NUM_LEVELS = 32,
    parameter int SRC_BITS   = 64,
    parameter int CMD_LVL_W  = 6,
    parameter int CMD_IDX_W  = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  post_vld,
    input  logic [CMD_LVL_W-1:0]  post_lvl,
    input  logic [CMD_IDX_W-1:0]  post_idx,
    input  logic                  clr_vld,
    input  logic [CMD_LVL_W-1:0]  clr_lvl,
    input  logic [CMD_IDX_W-1:0]  clr_idx,
    input  logic                  clr_all,
    output logic [NUM_LEVELS-1:0] status_o,
    output logic                  cmd_err_o
);
    localparam int IDX_W = $clog2(SRC_BITS);

    logic post_in_rng, clr_in_rng, post_ok, clr_ok;
    logic [SRC_BITS-1:0] post_oh, clr_oh;

    always_comb begin
        post_in_rng = (post_lvl < CMD_LVL_W'(NUM_LEVELS)) &&
                      (post_idx < CMD_IDX_W'(SRC_BITS));
        clr_in_rng  = (clr_lvl < CMD_LVL_W'(NUM_LEVELS)) &&
                      (clr_idx < CMD_IDX_W'(SRC_BITS));
        post_ok     = post_vld && post_in_rng;
        clr_ok      = clr_vld && clr_in_rng;
        post_oh     = SRC_BITS'(1) << post_idx[IDX_W-1:0];
        clr_oh      = SRC_BITS'(1) << clr_idx[IDX_W-1:0];
        cmd_err_o   = (post_vld && !post_in_rng) || (clr_vld && !clr_in_rng);
    end

    for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
        logic [SRC_BITS-1:0] bank_q, bank_d, set_m, clr_m;
        logic                stat_q;

        always_comb begin
            set_m = (post_ok && (post_lvl == CMD_LVL_W'(l))) ? post_oh : '0;
            clr_m = (clr_ok && (clr_lvl == CMD_LVL_W'(l))) ? clr_oh : '0;
            // a set applied after the clear lets the post win on a collision
            if (clr_all) begin
                bank_d = '0;
            end else begin
                bank_d = (bank_q & ~clr_m) | set_m;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_q <= '0;
                stat_q <= 1'b0;
            end else begin
                bank_q <= bank_d;
                stat_q <= |bank_d;
            end
        end

        assign status_o[l] = stat_q;
    end

endmodule

// File: rtl/irq_level_scan.sv
// Merges software requests with external level status and compares
// the winner against the current priority mask.
module irq_level_scan #(
    parameter int NUM_LEVELS = 32,
    parameter int SW_LO      = 1,
    parameter int SW_HI      = 16,
    parameter int EXT_LO     = 16,
    parameter int LVL_W      = 5
) (
    input  logic [NUM_LEVELS-1:0] sw_req,
    input  logic [NUM_LEVELS-1:0] status_i,
    input  logic [LVL_W-1:0]      cur_ipl,
    output logic [LVL_W-1:0]      lvl_o,
    output logic [NUM_LEVELS-1:0] sum_o,
    output logic                  irq_req_o
);
    always_comb begin
        lvl_o = '0;
        sum_o = '0;
        // software range first, ascending: highest set bit wins
        for (int i = 0; i < NUM_LEVELS; i++) begin
            if ((i >= SW_LO) && (i < SW_HI) && sw_req[i]) begin
                lvl_o    = LVL_W'(i - SW_LO + 1);
                sum_o[i] = 1'b1;
            end
        end
        // external range afterwards, so any pending level overrides
        for (int j = 0; j < NUM_LEVELS; j++) begin
            if ((j >= EXT_LO) && status_i[j]) begin
                lvl_o    = LVL_W'(j);
                sum_o[j] = 1'b1;
            end
        end
        irq_req_o = (lvl_o != '0) && (lvl_o > cur_ipl);
    end

endmodule

// File: rtl/irq_info_fsm.sv
// Holding stage and identification registers.
module irq_info_fsm
    import irq_level_pkg::*;
#(
    parameter int NUM_LEVELS = 32,
    parameter int LVL_W      = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  irq_req_i,
    input  logic [LVL_W-1:0]      lvl_i,
    input  logic [NUM_LEVELS-1:0] sum_i,
    input  logic                  ack_i,
    input  logic                  cmd_err_i,
    output logic                  info_vld_o,
    output logic [LVL_W-1:0]      intid_o,
    output logic [NUM_LEVELS-1:0] isr_o,
    output logic                  err_o
);
    info_state_e           state_q, state_d;
    logic [LVL_W-1:0]      lat_lvl_q;
    logic [NUM_LEVELS-1:0] lat_sum_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (irq_req_i) state_d = ST_HELD;   // IDLE->HELD
            ST_HELD: if (ack_i)     state_d = ST_IDLE;   // HELD->IDLE
            default: state_d = ST_IDLE;
        endcase
    end

    // held values, identification registers and error pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_lvl_q <= '0;
            lat_sum_q <= '0;
            intid_o   <= '0;
            isr_o     <= '0;
            err_o     <= 1'b0;
        end else begin
            err_o <= cmd_err_i || (ack_i && (state_q == ST_IDLE));
            unique case (state_q)
                ST_IDLE: begin
                    if (irq_req_i) begin
                        lat_lvl_q <= lvl_i;
                        lat_sum_q <= sum_i;
                    end
                end
                ST_HELD: begin
                    if (ack_i) begin
                        intid_o <= lat_lvl_q;
                        isr_o   <= lat_sum_q;
                    end else if (irq_req_i) begin   // HELD->HELD refresh
                        lat_lvl_q <= lvl_i;
                        lat_sum_q <= sum_i;
                    end
                end
                default: ;
            endcase
        end
    end

    assign info_vld_o = (state_q == ST_HELD);

endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl #(
    parameter int NUM_LEVELS = 32,
    parameter int SRC_BITS   = 64,
    parameter int SW_LO      = 1,
    parameter int SW_HI      = 16,
    parameter int EXT_LO     = 16,
    parameter int LVL_W      = $clog2(NUM_LEVELS),
    parameter int CMD_LVL_W  = LVL_W + 1,
    parameter int CMD_IDX_W  = $clog2(SRC_BITS) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  post_vld,
    input  logic [CMD_LVL_W-1:0]  post_lvl,
    input  logic [CMD_IDX_W-1:0]  post_idx,
    input  logic                  clr_vld,
    input  logic [CMD_LVL_W-1:0]  clr_lvl,
    input  logic [CMD_IDX_W-1:0]  clr_idx,
    input  logic                  clr_all,
    input  logic [NUM_LEVELS-1:0] sw_req,
    input  logic [LVL_W-1:0]      cur_ipl,
    input  logic [1:0]            pc_lo,
    input  logic                  ack,
    output logic                  pend,
    output logic                  irq_req,
    output logic                  info_vld,
    output logic [LVL_W-1:0]      intid_q,
    output logic [NUM_LEVELS-1:0] isr_q,
    output logic                  err
);
    logic [NUM_LEVELS-1:0] status;
    logic                  cmd_err;
    logic [LVL_W-1:0]      scan_lvl;
    logic [NUM_LEVELS-1:0] scan_sum;

    irq_src_bank #(
        .NUM_LEVELS(NUM_LEVELS), .SRC_BITS(SRC_BITS),
        .CMD_LVL_W(CMD_LVL_W),   .CMD_IDX_W(CMD_IDX_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .post_vld(post_vld), .post_lvl(post_lvl), .post_idx(post_idx),
        .clr_vld(clr_vld),   .clr_lvl(clr_lvl),   .clr_idx(clr_idx),
        .clr_all(clr_all),
        .status_o(status), .cmd_err_o(cmd_err)
    );

    irq_level_scan #(
        .NUM_LEVELS(NUM_LEVELS), .SW_LO(SW_LO), .SW_HI(SW_HI),
        .EXT_LO(EXT_LO),         .LVL_W(LVL_W)
    ) u_scan (
        .sw_req(sw_req), .status_i(status), .cur_ipl(cur_ipl),
        .lvl_o(scan_lvl), .sum_o(scan_sum), .irq_req_o(irq_req)
    );

    irq_info_fsm #(
        .NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .irq_req_i(irq_req), .lvl_i(scan_lvl), .sum_i(scan_sum),
        .ack_i(ack), .cmd_err_i(cmd_err),
        .info_vld_o(info_vld), .intid_o(intid_q), .isr_o(isr_q),
        .err_o(err)
    );

    assign pend = (|status) && (pc_lo == 2'b00);

endmodule

// File: rtl/irq_level_ctrl_chk.sv
module irq_level_ctrl_chk #(
    parameter int NUM_LEVELS = 32,
    parameter int LVL_W      = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  post_vld,
    input logic                  clr_vld,
    input logic                  clr_all,
    input logic [1:0]            pc_lo,
    input logic                  ack,
    input logic                  pend,
    input logic                  irq_req,
    input logic                  info_vld,
    input logic [LVL_W-1:0]      intid_q,
    input logic [NUM_LEVELS-1:0] isr_q,
    input logic                  err
);
    // R4
    pend_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> (pc_lo == 2'b00));

    // R3
    clear_all_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> !pend);

    // R9
    capture_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !info_vld) |=> info_vld);

    // R9
    ack_drops_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && info_vld) |=> !info_vld);

    // R9
    id_regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> ($stable(intid_q) && $stable(isr_q)));

    // R11
    stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !info_vld) |=> (err && $stable(intid_q) && $stable(isr_q)));

    // R10
    quiet_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!post_vld && !clr_vld && !ack) |=> !err);

    // R10
    clr_all_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && !post_vld && !clr_vld && !ack) |=> !err);

endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(
    .NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .post_vld(post_vld), .clr_vld(clr_vld),
    .clr_all(clr_all), .pc_lo(pc_lo), .ack(ack), .pend(pend),
    .irq_req(irq_req), .info_vld(info_vld), .intid_q(intid_q),
    .isr_q(isr_q), .err(err)
);

// File: tb/test_irq_level_ctrl.sv
module test_irq_level_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        post_vld = 1'b0, clr_vld = 1'b0, clr_all = 1'b0, ack = 1'b0;
    logic [5:0]  post_lvl = '0, clr_lvl = '0;
    logic [6:0]  post_idx = '0, clr_idx = '0;
    logic [31:0] sw_req = '0;
    logic [4:0]  cur_ipl = '0;
    logic [1:0]  pc_lo = '0;
    logic        pend, irq_req, info_vld, err;
    logic [4:0]  intid_q;
    logic [31:0] isr_q;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    irq_level_ctrl i_irq_level_ctrl (
        .clk(clk), .rst_n(rst_n),
        .post_vld(post_vld), .post_lvl(post_lvl), .post_idx(post_idx),
        .clr_vld(clr_vld), .clr_lvl(clr_lvl), .clr_idx(clr_idx),
        .clr_all(clr_all), .sw_req(sw_req), .cur_ipl(cur_ipl),
        .pc_lo(pc_lo), .ack(ack), .pend(pend), .irq_req(irq_req),
        .info_vld(info_vld), .intid_q(intid_q), .isr_q(isr_q), .err(err)
    );

    // op: 0 none, 1 post, 2 clear, 3 clear-all
    typedef struct packed {
        logic [1:0]  op;
        logic [5:0]  lvl;
        logic [6:0]  idx;
        logic [31:0] sw;
        logic [4:0]  ipl;
        logic        e_req;
        logic        e_pend;
        logic        e_err;
        logic [4:0]  e_lvl;
        logic [31:0] e_isr;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        // R1 R6: post level 16
        '{2'd1, 6'd16, 7'd3,  32'h0,         5'd0,  1'b1, 1'b1, 1'b0, 5'd16, 32'h0001_0000},
        // R1 R6: post level 20 top index
        '{2'd1, 6'd20, 7'd63, 32'h0,         5'd0,  1'b1, 1'b1, 1'b0, 5'd20, 32'h0011_0000},
        // R2: clear an unset bit, level 20 stays
        '{2'd2, 6'd20, 7'd5,  32'h0,         5'd0,  1'b1, 1'b1, 1'b0, 5'd20, 32'h0011_0000},
        // R2: last bit of level 20 cleared
        '{2'd2, 6'd20, 7'd63, 32'h0,         5'd0,  1'b1, 1'b1, 1'b0, 5'd16, 32'h0001_0000},
        // R6 R7: external overrides software 3 and 15
        '{2'd0, 6'd0,  7'd0,  32'h0000_8008, 5'd0,  1'b1, 1'b1, 1'b0, 5'd16, 32'h0001_8008},
        // R5 R2: external gone, software 15 wins
        '{2'd2, 6'd16, 7'd3,  32'h0000_8008, 5'd0,  1'b1, 1'b0, 1'b0, 5'd15, 32'h0000_8008},
        // R8: equal to mask, no request
        '{2'd0, 6'd0,  7'd0,  32'h0000_8008, 5'd15, 1'b0, 1'b0, 1'b0, 5'd0,  32'h0},
        // R8: one above mask
        '{2'd0, 6'd0,  7'd0,  32'h0000_8008, 5'd14, 1'b1, 1'b0, 1'b0, 5'd15, 32'h0000_8008},
        // R10: level out of range
        '{2'd1, 6'd40, 7'd0,  32'h0000_8008, 5'd14, 1'b1, 1'b0, 1'b1, 5'd15, 32'h0000_8008},
        // R10: index out of range, nothing posted
        '{2'd1, 6'd5,  7'd64, 32'h0000_8008, 5'd14, 1'b1, 1'b0, 1'b1, 5'd15, 32'h0000_8008},
        // R5: software bits 0 and 16 ignored
        '{2'd0, 6'd0,  7'd0,  32'h0001_0001, 5'd0,  1'b0, 1'b0, 1'b0, 5'd0,  32'h0},
        // R6: level 0 pending yet gives no level
        '{2'd1, 6'd0,  7'd0,  32'h0,         5'd0,  1'b0, 1'b1, 1'b0, 5'd0,  32'h0},
        // R3 R5: clear-all, software bit 2 still requests
        '{2'd3, 6'd0,  7'd0,  32'h0000_0004, 5'd0,  1'b1, 1'b0, 1'b0, 5'd2,  32'h0000_0004}
    };

    task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic idle_cmds();
        post_vld = 1'b0; clr_vld = 1'b0; clr_all = 1'b0; ack = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1;
        cyc();
        ack = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R9 reset state
        chk("R9", "reset info_vld", 64'(info_vld), 64'd0);
        chk("R9", "reset intid", 64'(intid_q), 64'd0);
        chk("R9", "reset isr", 64'(isr_q), 64'd0);
        chk("R4", "reset pend", 64'(pend), 64'd0);
        chk("R8", "reset irq_req", 64'(irq_req), 64'd0);
        rst_n = 1'b1;
        cyc();

        for (int v = 0; v < NV; v++) begin
            sw_req  = TBL[v].sw;
            cur_ipl = TBL[v].ipl;
            post_lvl = TBL[v].lvl; post_idx = TBL[v].idx;
            clr_lvl  = TBL[v].lvl; clr_idx  = TBL[v].idx;
            post_vld = (TBL[v].op == 2'd1);
            clr_vld  = (TBL[v].op == 2'd2);
            clr_all  = (TBL[v].op == 2'd3);
            cyc();
            idle_cmds();
            #1;
            chk("R8", $sformatf("vec%0d irq_req", v), 64'(irq_req), 64'(TBL[v].e_req));
            chk("R4", $sformatf("vec%0d pend", v), 64'(pend), 64'(TBL[v].e_pend));
            chk("R10", $sformatf("vec%0d err", v), 64'(err), 64'(TBL[v].e_err));
            if (TBL[v].e_req) begin
                cyc();
                chk("R9", $sformatf("vec%0d info_vld", v), 64'(info_vld), 64'd1);
                do_ack();
                chk("R9", $sformatf("vec%0d intid", v), 64'(intid_q), 64'(TBL[v].e_lvl));
                chk("R7", $sformatf("vec%0d isr", v), 64'(isr_q), 64'(TBL[v].e_isr));
            end
        end

        // R12: post and clear of the same bit in one cycle
        sw_req = '0; cur_ipl = '0;
        post_vld = 1'b1; post_lvl = 6'd18; post_idx = 7'd7;
        clr_vld  = 1'b1; clr_lvl  = 6'd18; clr_idx  = 7'd7;
        cyc();
        idle_cmds();
        #1;
        chk("R12", "pend after collision", 64'(pend), 64'd1);
        chk("R12", "irq_req after collision", 64'(irq_req), 64'd1);
        cyc();
        do_ack();
        chk("R12", "intid after collision", 64'(intid_q), 64'd18);
        chk("R12", "isr after collision", 64'(isr_q), 64'h0004_0000);

        // R3: clear-all overrides a simultaneous post
        clr_all = 1'b1;
        post_vld = 1'b1; post_lvl = 6'd25; post_idx = 7'd0;
        cyc();
        idle_cmds();
        #1;
        chk("R3", "pend after clear-all", 64'(pend), 64'd0);
        chk("R3", "irq_req after clear-all", 64'(irq_req), 64'd0);

        // R11: the first ack drains the held pair, the second is stray
        do_ack();
        cyc();
        chk("R9", "valid dropped", 64'(info_vld), 64'd0);
        do_ack();
        #1;
        chk("R11", "err on stray ack", 64'(err), 64'd1);
        chk("R11", "intid kept", 64'(intid_q), 64'd18);
        chk("R11", "isr kept", 64'(isr_q), 64'h0004_0000);
        cyc();
        chk("R11", "err is a pulse", 64'(err), 64'd0);

        // R4: program counter gating of pend, not of irq_req
        post_vld = 1'b1; post_lvl = 6'd17; post_idx = 7'd1;
        pc_lo = 2'b10;
        cyc();
        idle_cmds();
        #1;
        chk("R4", "pend pc=10", 64'(pend), 64'd0);
        chk("R8", "irq_req pc=10", 64'(irq_req), 64'd1);
        pc_lo = 2'b01;
        #1;
        chk("R4", "pend pc=01", 64'(pend), 64'd0);
        pc_lo = 2'b00;
        #1;
        chk("R4", "pend pc=00", 64'(pend), 64'd1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule